// File: doc/BRIEF.md
# Raster LCD Horizontal Line Timing Generator

This block sequences the horizontal part of a raster LCD scan. Each line has three phases: a run of pixel periods, a short end-of-line wait, and a line clock (horizontal sync) pulse. After the pulse the next line starts. Each phase is timed by one down counter. The counter moves only on system-clock cycles where the pixel tick input is high, so the tick sets the pixel rate.

The pixel count field holds the line length minus 16. Its four least significant bits are ignored, so every line is a multiple of 16 pixels long. A panel that is narrower than that simply receives padding pixels. The end-of-line wait and the sync width are each programmed as their length minus one.

In passive mode the pixel clock output freezes during the wait and the sync pulse. In active mode it keeps toggling through them. The active level of the line clock is set by a polarity input. The configuration is captured at the start of each line, so a change made mid-line first applies to the following line.

Top module: `lcd_hline_gen`

## Requirements
- R1: The reset is synchronous and active low. While it is asserted, the configuration is captured. After it is released, the block is in the pixel phase with `pclk_out` = 0, `line_done` = 0 and `lclk_out` at its inactive level (the inverse of `hsync_pol`).
- R2: Each line has exactly (`cfg_ppl`[9:4] + 1) × 16 pixel ticks with `pix_valid` high, giving 16 to 1024 pixels. Bits [3:0] of `cfg_ppl` have no effect.
- R3: After the last valid pixel, exactly `cfg_elw` + 1 ticks pass with neither `pix_valid` high nor the line clock active.
- R4: The line clock is active for exactly `cfg_hsw` + 1 ticks per line.
- R5: `line_done` is high for one cycle, on the final tick of the sync pulse. The next cycle returns to the pixel phase with the line clock inactive.
- R6: In both modes, `pclk_out` changes in the cycle after every pixel-phase tick, so it toggles once per valid pixel.
- R7: With `active_mode` = 0, `pclk_out` does not change during the end-of-line wait or the sync pulse.
- R8: With `active_mode` = 1, `pclk_out` toggles on every tick of the end-of-line wait and the sync pulse.
- R9: The active level of `lclk_out` equals `hsync_pol`: 1 means active high, 0 means active low.
- R10: Configuration inputs are captured on the tick that ends a line. A change made mid-line does not alter the current line and governs the next one.
- R11: `pix_valid` is high only in cycles where `pix_tick` is high. No counter or output register moves in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_tick | input | 1 | Pixel-rate enable; all timing advances only when high |
| cfg_ppl | input | 10 | Line length minus 16; bits [3:0] ignored |
| cfg_elw | input | 8 | End-of-line wait length minus one, in ticks |
| cfg_hsw | input | 6 | Sync pulse width minus one, in ticks |
| active_mode | input | 1 | 1: pixel clock runs continuously; 0: it freezes outside the pixel phase |
| hsync_pol | input | 1 | Active level of the line clock |
| pclk_out | output | 1 | Pixel clock, toggling once per enabled tick |
| pix_valid | output | 1 | High on ticks in the pixel phase |
| lclk_out | output | 1 | Line clock / horizontal sync |
| line_done | output | 1 | One-cycle strobe on the final sync tick |

## Verification
`pix_valid` and `line_done` are combinational from the phase register and the current tick, so they are due in the same cycle as that tick. `lclk_out` changes one cycle after the tick that enters or leaves the sync phase. `pclk_out` changes one cycle after an enabled tick. A configuration change shows up only in the line after the one in progress.

The bench drives inputs one time unit after the rising edge and samples on the falling edge. Each tick is sorted by what is visible in that same sample (valid pixel, active line clock, or neither). Each pixel-clock change is credited to the tick seen in the previous sample. Per-line counts are latched in the sample after `line_done`, so that the last sync tick's toggle is included.

// File: rtl/lcd_hline_pkg.sv
package lcd_hline_pkg;
  typedef enum logic [1:0] {
    PH_PIX  = 2'd0,
    PH_EOL  = 2'd1,
    PH_SYNC = 2'd2
  } hphase_e;
endpackage

// File: rtl/lcd_hline_shadow.sv
module lcd_hline_shadow #(
  parameter int ELW_W = 8,
  parameter int HSW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ELW_W-1:0] cfg_elw,
  input  logic [HSW_W-1:0] cfg_hsw,
  output logic [ELW_W-1:0] sh_elw,
  output logic [HSW_W-1:0] sh_hsw
);
  // Capture during reset and at each line start
  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      sh_elw <= cfg_elw;
      sh_hsw <= cfg_hsw;
    end
  end
endmodule

// File: rtl/lcd_hline_seq.sv
module lcd_hline_seq
  import lcd_hline_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int ELW_W = 8,
  parameter int HSW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] pix_last,
  input  logic [ELW_W-1:0] sh_elw,
  input  logic [HSW_W-1:0] sh_hsw,
  output hphase_e          phase,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             line_start
);
  function automatic logic [CNT_W-1:0] widen_elw(input logic [ELW_W-1:0] v);
    return CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] widen_hsw(input logic [HSW_W-1:0] v);
    return CNT_W'(v);
  endfunction

  assign cnt_zero   = (cnt == '0);
  assign line_start = tick && (phase == PH_SYNC) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_PIX;
      cnt   <= pix_last;
    end else if (tick) begin
      unique case (phase)
        PH_PIX: begin
          if (cnt_zero) begin
            phase <= PH_EOL;
            cnt   <= widen_elw(sh_elw);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_EOL: begin
          if (cnt_zero) begin
            phase <= PH_SYNC;
            cnt   <= widen_hsw(sh_hsw);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SYNC: begin
          if (cnt_zero) begin
            phase <= PH_PIX;
            cnt   <= pix_last;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          phase <= PH_PIX;
          cnt   <= pix_last;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_hline_pclk.sv
module lcd_hline_pclk (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic pclk
);
  always_ff @(posedge clk) begin
    if (!rst_n)          pclk <= 1'b0;
    else if (tick && run) pclk <= ~pclk;
  end
endmodule

// File: rtl/lcd_hline_gen.sv
module lcd_hline_gen
  import lcd_hline_pkg::*;
#(
  parameter int PPL_W    = 10,
  parameter int PAD_BITS = 4,
  parameter int ELW_W    = 8,
  parameter int HSW_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_tick,
  input  logic [PPL_W-1:0] cfg_ppl,
  input  logic [ELW_W-1:0] cfg_elw,
  input  logic [HSW_W-1:0] cfg_hsw,
  input  logic             active_mode,
  input  logic             hsync_pol,
  output logic             pclk_out,
  output logic             pix_valid,
  output logic             lclk_out,
  output logic             line_done
);
  localparam int MAX_A = (PPL_W > ELW_W) ? PPL_W : ELW_W;
  localparam int CNT_W = (MAX_A > HSW_W) ? MAX_A : HSW_W;

  // Last pixel index: masked field + 16 - 1, i.e. the pad bits forced to ones
  function automatic logic [CNT_W-1:0] last_pix_idx(input logic [PPL_W-1:0] f);
    return CNT_W'(f | PPL_W'((1 << PAD_BITS) - 1));
  endfunction

  hphase_e              phase;
  logic [CNT_W-1:0]     cnt;
  logic                 cnt_zero;
  logic                 line_start;
  logic [ELW_W-1:0]     sh_elw;
  logic [HSW_W-1:0]     sh_hsw;
  logic [CNT_W-1:0]     pix_last;
  logic                 in_pix;
  logic                 in_sync;

  assign pix_last = last_pix_idx(cfg_ppl);
  assign in_pix   = (phase == PH_PIX);
  assign in_sync  = (phase == PH_SYNC);

  lcd_hline_shadow #(.ELW_W(ELW_W), .HSW_W(HSW_W)) shadow_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (line_start),
    .cfg_elw (cfg_elw),
    .cfg_hsw (cfg_hsw),
    .sh_elw  (sh_elw),
    .sh_hsw  (sh_hsw)
  );

  lcd_hline_seq #(.CNT_W(CNT_W), .ELW_W(ELW_W), .HSW_W(HSW_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (pix_tick),
    .pix_last   (pix_last),
    .sh_elw     (sh_elw),
    .sh_hsw     (sh_hsw),
    .phase      (phase),
    .cnt        (cnt),
    .cnt_zero   (cnt_zero),
    .line_start (line_start)
  );

  lcd_hline_pclk pclk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pix_tick),
    .run   (active_mode || in_pix),
    .pclk  (pclk_out)
  );

  assign pix_valid = pix_tick && in_pix;
  assign line_done = line_start;
  assign lclk_out  = in_sync ? hsync_pol : ~hsync_pol;
endmodule

// File: rtl/lcd_hline_gen_chk.sv
module lcd_hline_gen_chk #(
  parameter int CNT_W    = 10,
  parameter int PAD_BITS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_tick,
  input logic             active_mode,
  input logic             pclk_out,
  input logic             pix_valid,
  input logic             line_done,
  input logic             in_pix,
  input logic             in_sync,
  input logic             cnt_zero,
  input logic [CNT_W-1:0] cnt
);
  // R11
  valid_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_tick);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_tick |=> ($stable(cnt) && $stable(pclk_out) && $stable(in_pix)));

  // R7
  passive_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_mode && !in_pix) |=> $stable(pclk_out));

  // R6
  pclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_tick && (active_mode || in_pix)) |=> (pclk_out != $past(pclk_out)));

  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (in_pix && !in_sync && !line_done));

  // R2
  line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (cnt[PAD_BITS-1:0] == {PAD_BITS{1'b1}}));

  // R3
  eol_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_tick && !in_pix && !in_sync && cnt_zero) |=> in_sync);
endmodule

bind lcd_hline_gen lcd_hline_gen_chk #(.CNT_W(CNT_W), .PAD_BITS(PAD_BITS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_tick    (pix_tick),
  .active_mode (active_mode),
  .pclk_out    (pclk_out),
  .pix_valid   (pix_valid),
  .line_done   (line_done),
  .in_pix      (in_pix),
  .in_sync     (in_sync),
  .cnt_zero    (cnt_zero),
  .cnt         (cnt)
);

// File: tb/lcd_hline_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_hline_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_tick = 1'b0;
  logic [9:0] cfg_ppl = '0;
  logic [7:0] cfg_elw = '0;
  logic [5:0] cfg_hsw = '0;
  logic       active_mode = 1'b0;
  logic       hsync_pol = 1'b1;
  logic       pclk_out, pix_valid, lclk_out, line_done;

  always #4 clk = ~clk;  // 125 MHz

  lcd_hline_gen dut_i (
    .clk (clk), .rst_n (rst_n), .pix_tick (pix_tick),
    .cfg_ppl (cfg_ppl), .cfg_elw (cfg_elw), .cfg_hsw (cfg_hsw),
    .active_mode (active_mode), .hsync_pol (hsync_pol),
    .pclk_out (pclk_out), .pix_valid (pix_valid),
    .lclk_out (lclk_out), .line_done (line_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int tick_div = 0;   // 0: no ticks, k: one tick every k cycles

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Tick generator, driven just after the rising edge
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      if (tick_div == 0) begin
        pix_tick = 1'b0;
        ph = 0;
      end else begin
        pix_tick = (ph == 0);
        ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
      end
    end
  end

  // Line monitor, sampling on the falling edge
  int acc_pix, acc_eol, acc_sync, acc_tpix, acc_tes;
  int last_pix, last_eol, last_sync, last_tpix, last_tes;
  int line_count, mon_err;
  bit latch_pend, prev_tick, prev_pclk, prev_done;
  int prev_cat;

  always @(negedge clk) begin
    int cat;
    bit lact;
    cat  = 0;
    lact = (lclk_out == hsync_pol);
    if (!rst_n) begin
      acc_pix = 0; acc_eol = 0; acc_sync = 0; acc_tpix = 0; acc_tes = 0;
      line_count = 0; latch_pend = 0; prev_tick = 0; prev_pclk = 0;
      prev_done = 0; prev_cat = 0;
    end else begin
      if (pclk_out != prev_pclk) begin
        if (!prev_tick) mon_err++;
        else if (prev_cat == 0) acc_tpix++;
        else acc_tes++;
      end
      if (latch_pend) begin
        last_pix = acc_pix; last_eol = acc_eol; last_sync = acc_sync;
        last_tpix = acc_tpix; last_tes = acc_tes;
        acc_pix = 0; acc_eol = 0; acc_sync = 0; acc_tpix = 0; acc_tes = 0;
        line_count++;
        latch_pend = 0;
        if (lact) mon_err++;               // R5: line clock released
      end
      if (pix_tick) begin
        if (pix_valid) begin cat = 0; acc_pix++; end
        else if (lact) begin cat = 2; acc_sync++; end
        else begin cat = 1; acc_eol++; end
      end
      if (pix_valid && !pix_tick) mon_err++;          // R11
      if (line_done && (!pix_tick || !lact)) mon_err++; // R5
      if (line_done && prev_done) mon_err++;            // R5 one cycle
      if (line_done) latch_pend = 1;
      prev_done = line_done;
      prev_pclk = pclk_out;
      prev_tick = pix_tick;
      prev_cat  = cat;
    end
  end

  task automatic wait_lines(input int n, input string tag);
    int t = 0;
    while (line_count < n && t < 30000) begin
      @(posedge clk);
      t++;
    end
    chk(line_count >= n, tag, line_count, n);
  endtask

  task automatic do_reset(input logic [9:0] p, input logic [7:0] e, input logic [5:0] h,
                          input bit act, input bit pol);
    @(posedge clk); #1;
    rst_n = 1'b0; tick_div = 0;
    cfg_ppl = p; cfg_elw = e; cfg_hsw = h; active_mode = act; hsync_pol = pol;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // R1: state right after reset release
  task automatic t_reset_state(input bit pol);
    do_reset(10'h000, 8'd0, 6'd0, 1'b0, pol);
    @(negedge clk);
    chk(pclk_out == 1'b0, "R1 pclk_out after reset", pclk_out, 0);
    chk(line_done == 1'b0, "R1 line_done after reset", line_done, 0);
    chk(lclk_out == ~pol, "R1 R9 lclk inactive after reset", lclk_out, ~pol);
    chk(pix_valid == 1'b0, "R1 R11 pix_valid without tick", pix_valid, 0);
    repeat (5) @(negedge clk);
    chk(pclk_out == 1'b0, "R11 pclk holds without ticks", pclk_out, 0);
  endtask

  // R2 R3 R4 R6 R7 R8 R9: measure the second full line
  task automatic t_line(input logic [9:0] p, input logic [7:0] e, input logic [5:0] h,
                        input bit act, input bit pol, input int div);
    int exp_pix;
    exp_pix = (int'(p >> 4) + 1) * 16;
    mon_err = 0;
    do_reset(p, e, h, act, pol);
    tick_div = div;
    wait_lines(2, "R5 lines complete");
    chk(last_pix == exp_pix, "R2 pixels per line", last_pix, exp_pix);
    chk(last_eol == int'(e) + 1, "R3 end-of-line wait ticks", last_eol, int'(e) + 1);
    chk(last_sync == int'(h) + 1, "R4 R9 sync ticks at hsync_pol level", last_sync, int'(h) + 1);
    chk(last_tpix == exp_pix, "R6 pclk toggles in pixel phase", last_tpix, exp_pix);
    if (act)
      chk(last_tes == int'(e) + int'(h) + 2, "R8 active pclk toggles", last_tes,
          int'(e) + int'(h) + 2);
    else
      chk(last_tes == 0, "R7 passive pclk frozen", last_tes, 0);
    chk(mon_err == 0, "R5 R11 strobe and valid timing", mon_err, 0);
  endtask

  // R10: mid-line change applies to the next line only
  task automatic t_shadow;
    int t = 0;
    mon_err = 0;
    do_reset(10'h010, 8'd3, 6'd1, 1'b1, 1'b1);
    tick_div = 1;
    while (acc_pix < 6 && t < 1000) begin @(posedge clk); t++; end
    #1;
    cfg_ppl = 10'h030; cfg_elw = 8'd7; cfg_hsw = 6'd2;
    wait_lines(1, "R10 first line");
    chk(last_pix == 32, "R10 current line keeps old length", last_pix, 32);
    chk(last_eol == 4, "R10 current line keeps old wait", last_eol, 4);
    chk(last_sync == 2, "R10 current line keeps old sync", last_sync, 2);
    wait_lines(2, "R10 second line");
    chk(last_pix == 64, "R10 next line new length", last_pix, 64);
    chk(last_eol == 8, "R10 next line new wait", last_eol, 8);
    chk(last_sync == 3, "R10 next line new sync", last_sync, 3);
    chk(mon_err == 0, "R5 strobe timing in R10 run", mon_err, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    mon_err = 0;
    t_reset_state(1'b1);
    t_reset_state(1'b0);
    t_line(10'h000, 8'd0,   6'd0,  1'b0, 1'b1, 1);  // minimum everything
    t_line(10'h0F7, 8'd5,   6'd3,  1'b1, 1'b0, 3);  // low bits ignored: 256
    t_line(10'h3FF, 8'd255, 6'd63, 1'b0, 1'b1, 1);  // maximum everything
    t_line(10'h02A, 8'd2,   6'd1,  1'b1, 1'b1, 2);  // 48 pixels
    t_shadow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule